// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog Timer

This block is a watchdog that escalates through four timeout stages when software stops servicing it. A prescaler divides the bus clock into watchdog ticks. Each stage counts ticks up to its own 32-bit threshold. When a stage expires, the block applies that stage's action and starts the next stage from zero. After the last stage it wraps back to the first. The action for a stage is one of four: nothing, raise an interrupt, reset the CPU, or reset the whole system. The interrupt is a sticky level output that software clears. The two reset outputs are pulses whose lengths software programs.

Software reaches the block through a plain word-addressed register port. Writes take one cycle and reads are combinational. There is no data stream, so the port has no valid/ready handshake. A write is accepted in the cycle `wr_en` is high, and it is never back-pressured. While the watchdog runs, the configuration registers are locked. A fixed 32-bit key opens them, and writing any other value to the key register closes them again. Writing the feed register restarts the escalation at stage 0.

Top module: `wdog_escalator`

## Requirements
- R1: After reset the block is locked and stopped, and stage_o is 0. irq_o, cpu_rst_o and sys_rst_o are low, and reading address 0 returns 1.
- R2: Writing 32'h5A3C96E1 to address 0 unlocks the block, after which address 0 reads 0. Writing any other value there locks it, after which address 0 reads 1.
- R3: While the watchdog runs and the block is locked, writes to address 1 (control), address 2 (prescale) and addresses 4..7 (stage thresholds 0..3) are ignored. While it is stopped, these writes take effect whether or not the block is locked. Every one of these registers reads back its stored value.
- R4: One tick occurs every P clock cycles, where P is the 16-bit prescale value. A value of 0 acts as 1.
- R5: Stage s expires on the tick that brings its count to max(threshold s, 1). stage_o then moves to the next stage with the count at zero, and stage 3 is followed by stage 0.
- R6: A write to address 3 while the watchdog runs restarts stage 0 and clears both the tick count and the prescaler. While the watchdog is stopped, the write has no effect.
- R7: Control layout, from bit 0 upward:
  - bit 0: run
  - bit 1: boot-mode enable (stored only)
  - bit 2: interrupt enable
  - bits 3+2s..4+2s: action code for stage s (0 none, 1 interrupt, 2 CPU reset, 3 system reset)
  - bits 13:11: CPU reset length
  - bits 16:14: system reset length

  Clearing run returns stage_o to 0 and clears the counts.
- R8: An expiry with action 1 sets a sticky raw interrupt flag, and irq_o equals that flag ANDed with the interrupt enable. Writing 1 in bit 0 of address 8 clears the flag, but an expiry in the same cycle wins. Address 8 reads the flag in bit 0 and irq_o in bit 1.
- R9: An expiry with action 2 or 3 drives cpu_rst_o or sys_rst_o high from the next cycle for (L+1)*PULSE_UNIT cycles, where L is the matching 3-bit length. A new expiry of the same kind reloads the length.
- R10: An expiry with action 0 changes no output other than stage_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 1 | Level watchdog interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |
| stage_o | output | 2 | Current escalation stage |

## Verification
The bench builds the block with PULSE_UNIT set to 2, so the longest reset pulse is 16 cycles and several pulses fit into one run. Prescale and threshold widths keep their defaults. The bench programs thresholds of 0 to 10 ticks and prescales of 0 to 3, so every stage, the wrap from stage 3 to stage 0, and the retriggering of a pulse all occur within a few hundred cycles. Under those settings it compares the outputs and the read data each cycle against a behavioural model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int N_STAGES = 4;
  localparam int STG_W    = $clog2(N_STAGES);
  localparam int LEN_W    = 3;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h5A3C_96E1;

  localparam logic [ADDR_W-1:0] A_KEY   = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'd2;
  localparam logic [ADDR_W-1:0] A_FEED  = 4'd3;
  localparam logic [ADDR_W-1:0] A_THR0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_IRQ   = 4'd8;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CPU  = 2'd2,
    ACT_SYS  = 2'd3
  } wd_act_e;

  typedef struct packed {
    logic [LEN_W-1:0]          sys_len;
    logic [LEN_W-1:0]          cpu_len;
    logic [N_STAGES-1:0][1:0]  act;
    logic                      irq_en;
    logic                      boot;
    logic                      run;
  } wd_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int THR_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic                             irq_raw,
  input  logic                             irq_out,
  output wd_ctrl_t                         ctrl,
  output logic [PRE_W-1:0]                 presc,
  output logic [N_STAGES-1:0][THR_W-1:0]   thr,
  output logic                             locked,
  output logic                             feed_acc,
  output logic                             irq_clr,
  output logic [DATA_W-1:0]                rd_data
);
  localparam int CTRL_W = $bits(wd_ctrl_t);

  logic cfg_ok;
  assign cfg_ok   = !locked || !ctrl.run;
  assign feed_acc = wr_en && (wr_addr == A_FEED) && ctrl.run;
  assign irq_clr  = wr_en && (wr_addr == A_IRQ) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
      ctrl   <= '0;
      presc  <= '0;
      thr    <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_KEY) locked <= (wr_data != UNLOCK_KEY);
      if (cfg_ok) begin
        if (wr_addr == A_CTRL)  ctrl  <= wd_ctrl_t'(wr_data[CTRL_W-1:0]);
        if (wr_addr == A_PRESC) presc <= wr_data[PRE_W-1:0];
        for (int s = 0; s < N_STAGES; s++) begin
          if (wr_addr == ADDR_W'(int'(A_THR0) + s)) thr[s] <= wr_data[THR_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_KEY:   rd_data = DATA_W'(locked);
      A_CTRL:  rd_data = DATA_W'(ctrl);
      A_PRESC: rd_data = DATA_W'(presc);
      A_IRQ:   rd_data = DATA_W'({irq_out, irq_raw});
      default: begin
        for (int s = 0; s < N_STAGES; s++) begin
          if (rd_addr == ADDR_W'(int'(A_THR0) + s)) rd_data = DATA_W'(thr[s]);
        end
      end
    endcase
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int THR_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            run,
  input  logic                            feed,
  input  logic [PRE_W-1:0]                presc,
  input  logic [N_STAGES-1:0][THR_W-1:0]  thr,
  output logic [STG_W-1:0]                stage,
  output logic                            expire
);
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic [THR_W-1:0] tick_cnt;
  logic [THR_W:0]   nxt_ticks;
  logic             tick, stage_hit;

  assign pre_lim   = (presc == '0) ? PRE_W'(1) : presc;
  assign tick      = run && (pre_cnt >= pre_lim - PRE_W'(1));
  assign nxt_ticks = {1'b0, tick_cnt} + (THR_W+1)'(1);
  assign stage_hit = nxt_ticks >= {1'b0, thr[stage]};
  assign expire    = tick && !feed && stage_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
      stage    <= '0;
    end else if (!run || feed) begin
      pre_cnt  <= '0;
      tick_cnt <= '0;
      stage    <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      if (stage_hit) begin
        tick_cnt <= '0;
        stage    <= (stage == STG_W'(N_STAGES-1)) ? '0 : stage + STG_W'(1);
      end else begin
        tick_cnt <= nxt_ticks[THR_W-1:0];
      end
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int UNIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  localparam int MAX_LEN = (1 << LEN_W) * UNIT;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt, width;
  assign width  = CNT_W'((int'(len) + 1) * UNIT);
  assign active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= width;
    else if (active)  cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
#(
  parameter int PRE_W      = 16,
  parameter int THR_W      = 32,
  parameter int PULSE_UNIT = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq_o,
  output logic        cpu_rst_o,
  output logic        sys_rst_o,
  output logic [1:0]  stage_o
);
  wd_ctrl_t                        ctrl;
  logic [PRE_W-1:0]                presc;
  logic [N_STAGES-1:0][THR_W-1:0]  thr;
  logic                            locked, feed_acc, irq_clr, irq_raw, expire;
  logic [STG_W-1:0]                stage;
  wd_act_e                         act;
  logic [1:0]                      pl_load, pl_out;
  logic [1:0][LEN_W-1:0]           pl_len;

  wdog_regs #(.PRE_W(PRE_W), .THR_W(THR_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr,
    .irq_raw, .irq_out(irq_o), .ctrl, .presc, .thr, .locked,
    .feed_acc, .irq_clr, .rd_data
  );

  wdog_core #(.PRE_W(PRE_W), .THR_W(THR_W)) u_core (
    .clk, .rst_n, .run(ctrl.run), .feed(feed_acc), .presc, .thr,
    .stage, .expire
  );

  assign act = wd_act_e'(ctrl.act[stage]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          irq_raw <= 1'b0;
    else if (expire && act == ACT_IRQ)   irq_raw <= 1'b1;
    else if (irq_clr)                    irq_raw <= 1'b0;
  end
  assign irq_o = irq_raw && ctrl.irq_en;

  assign pl_load[0] = expire && (act == ACT_CPU);
  assign pl_load[1] = expire && (act == ACT_SYS);
  assign pl_len[0]  = ctrl.cpu_len;
  assign pl_len[1]  = ctrl.sys_len;

  for (genvar g = 0; g < 2; g++) begin : g_pulse
    wdog_pulse #(.UNIT(PULSE_UNIT)) u_pulse (
      .clk, .rst_n, .load(pl_load[g]), .len(pl_len[g]), .active(pl_out[g])
    );
  end

  assign cpu_rst_o = pl_out[0];
  assign sys_rst_o = pl_out[1];
  assign stage_o   = 2'(stage);
endmodule

// File: rtl/wdog_escalator_checker.sv
module wdog_escalator_checker
  import wdog_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input wd_ctrl_t    ctrl,
  input logic        locked,
  input logic        feed_acc,
  input logic        expire,
  input wd_act_e     act,
  input logic        irq_raw,
  input logic        irq_o,
  input logic        cpu_rst_o,
  input logic        sys_rst_o,
  input logic [1:0]  stage_o
);
  // R3: a locked, running block keeps its control word
  a_r3_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && locked && ctrl.run) |=> $stable(ctrl));

  // R5: stages only step forward by one or return to zero
  a_r5_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_o != $past(stage_o)) |-> (stage_o == 2'($past(stage_o) + 2'd1) || stage_o == 2'd0));

  // R6: an accepted feed puts the sequence back at stage 0
  a_r6_feed_restart: assert property (@(posedge clk) disable iff (!rst_n)
    feed_acc |=> (stage_o == 2'd0));

  // R7: a stopped watchdog sits at stage 0
  a_r7_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.run |=> (stage_o == 2'd0));

  // R8: the flag only rises after an interrupt-action expiry; the pin needs the enable
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_raw) |-> $past(expire && act == ACT_IRQ));
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl.irq_en);

  // R9: reset pulses start only from matching expiries
  a_r9_cpu_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_o) |-> $past(expire && act == ACT_CPU));
  a_r9_sys_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(expire && act == ACT_SYS));
endmodule

bind wdog_escalator wdog_escalator_checker u_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .ctrl(ctrl),
  .locked(locked), .feed_acc(feed_acc), .expire(expire), .act(act),
  .irq_raw(irq_raw), .irq_o(irq_o), .cpu_rst_o(cpu_rst_o),
  .sys_rst_o(sys_rst_o), .stage_o(stage_o)
);

// File: tb/wdog_escalator_bench.sv
module wdog_escalator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 2;
  localparam int KEY        = 32'h5A3C96E1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o, cpu_rst_o, sys_rst_o;
  logic [1:0]  stage_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit seen_irq = 0, seen_cpu = 0, seen_sys = 0, seen_wrap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_escalator #(.PULSE_UNIT(UNIT)) u_wdog_escalator (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .irq_o, .cpu_rst_o, .sys_rst_o, .stage_o
  );

  // behavioural reference state
  int  m_ctrl, m_presc, m_locked, m_pcnt, m_stage, m_irq, m_cpu, m_sys;
  longint m_tcnt;
  longint m_thr [4];

  function automatic int bits(int v, int lo, int w);
    return (v >> lo) & ((1 << w) - 1);
  endfunction

  function automatic int model_read(int a);
    case (a)
      0: return m_locked;
      1: return m_ctrl;
      2: return m_presc;
      4, 5, 6, 7: return int'(m_thr[a-4]);
      8: return m_irq | ((m_irq & bits(m_ctrl, 2, 1)) << 1);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_presc = 0; m_locked = 1; m_pcnt = 0; m_tcnt = 0;
      m_stage = 0; m_irq = 0; m_cpu = 0; m_sys = 0;
      foreach (m_thr[i]) m_thr[i] = 0;
    end else begin
      int run, feed, cfg_ok, lim, tick, expire, act;
      run    = bits(m_ctrl, 0, 1);
      feed   = (wr_en && wr_addr == 3 && run) ? 1 : 0;
      cfg_ok = (!m_locked || !run) ? 1 : 0;
      lim    = (m_presc == 0) ? 1 : m_presc;
      tick   = (run && m_pcnt >= lim - 1) ? 1 : 0;
      expire = (tick && !feed && (m_tcnt + 1 >= m_thr[m_stage])) ? 1 : 0;
      act    = bits(m_ctrl, 3 + 2*m_stage, 2);
      if (expire && m_stage == 3) seen_wrap = 1;
      if (!run || feed) begin
        m_pcnt = 0; m_tcnt = 0; m_stage = 0;
      end else if (tick) begin
        m_pcnt = 0;
        if (expire) begin m_tcnt = 0; m_stage = (m_stage + 1) % 4; end
        else m_tcnt = m_tcnt + 1;
      end else m_pcnt = m_pcnt + 1;
      if (expire && act == 2) m_cpu = (bits(m_ctrl, 11, 3) + 1) * UNIT;
      else if (m_cpu > 0) m_cpu = m_cpu - 1;
      if (expire && act == 3) m_sys = (bits(m_ctrl, 14, 3) + 1) * UNIT;
      else if (m_sys > 0) m_sys = m_sys - 1;
      if (expire && act == 1) m_irq = 1;
      else if (wr_en && wr_addr == 8 && wr_data[0]) m_irq = 0;
      if (wr_en) begin
        if (wr_addr == 0) m_locked = (wr_data != KEY) ? 1 : 0;
        if (cfg_ok) begin
          if (wr_addr == 1) m_ctrl  = int'(wr_data & 32'h1FFFF);
          if (wr_addr == 2) m_presc = int'(wr_data & 32'hFFFF);
          if (wr_addr >= 4 && wr_addr <= 7) m_thr[wr_addr-4] = longint'(wr_data);
        end
      end
    end
  end

  task automatic chk(string req, longint act_v, longint exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 stage_o", stage_o, m_stage);
      chk("R8 irq_o", irq_o, m_irq & bits(m_ctrl, 2, 1));
      chk("R9 cpu_rst_o", cpu_rst_o, m_cpu != 0);
      chk("R9 sys_rst_o", sys_rst_o, m_sys != 0);
      chk("R3 rd_data", rd_data, model_read(int'(rd_addr)));
      if (irq_o) seen_irq = 1;
      if (cpu_rst_o) seen_cpu = 1;
      if (sys_rst_o) seen_sys = 1;
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, int exp_v);
    rd_addr = 4'(a);
    @(negedge clk);
    chk(req, rd_data, exp_v);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd_chk("R1 locked after reset", 0, 1);
    chk("R1 stage_o", stage_o, 0);
    chk("R1 outputs", {irq_o, cpu_rst_o, sys_rst_o}, 0);

    // R3 stopped block accepts config while locked
    wr(2, 2);
    rd_chk("R3 prescale written while stopped", 2, 2);
    wr(4, 3); wr(5, 1); wr(6, 2); wr(7, 0);
    rd_chk("R3 threshold 0 readback", 4, 3);
    // run, irq_en, act0=IRQ act1=CPU act2=SYS act3=NONE, cpu_len=1, sys_len=0
    wr(1, 2509);
    idle(60);
    chk("R8 interrupt seen", seen_irq, 1);
    chk("R9 cpu pulse seen", seen_cpu, 1);
    chk("R9 sys pulse seen", seen_sys, 1);
    chk("R5 wrap after stage 3", seen_wrap, 1);

    // R3 locked and running: writes ignored
    wr(2, 7);
    rd_chk("R3 prescale held while locked", 2, 2);
    wr(1, 0);
    rd_chk("R3 control held while locked", 1, 2509);

    // R2 key behaviour
    wr(0, KEY);
    rd_chk("R2 unlocked by key", 0, 0);
    wr(2, 0);
    rd_chk("R4 prescale zero accepted", 2, 0);
    wr(4, 10);
    wr(0, 32'h1234);
    rd_chk("R2 relocked by other value", 0, 1);

    // R8 clear
    wr(8, 1);
    idle(3);

    // R6 feed keeps stage 0
    for (int i = 0; i < 10; i++) begin
      wr(3, 0);
      chk("R6 stage after feed", stage_o, 0);
      idle(2);
    end
    idle(30);

    // R7 stop clears stage; gate interrupt off
    wr(0, KEY);
    wr(4, 1); wr(5, 8);
    wr(1, 1 | (1 << 3));
    idle(3);
    wr(1, 0);
    idle(1);
    chk("R7 stage cleared on stop", stage_o, 0);
    idle(3);
    chk("R7 stage stays 0 while stopped", stage_o, 0);
    wr(3, 0);
    chk("R6 feed while stopped leaves stage 0", stage_o, 0);

    // R8 interrupt enable off: flag set, pin low
    wr(8, 1);
    wr(2, 3);
    wr(1, 1 | (1 << 3));
    idle(12);
    rd_chk("R8 raw set, pin gated", 8, 1);
    chk("R8 irq_o gated", irq_o, 0);

    // R9 retrigger: all stages CPU reset, long length; R10 none-action stage
    wr(1, 0);
    wr(2, 1);
    wr(4, 4); wr(5, 4); wr(6, 4); wr(7, 4);
    wr(1, 1 | (2 << 3) | (2 << 5) | (2 << 7) | (0 << 9) | (7 << 11));
    idle(60);
    chk("R9 retriggered pulse still high", cpu_rst_o, 1);
    chk("R10 no system reset from none action", sys_rst_o, 0);
    wr(1, 0);
    idle(40);
    chk("R9 pulse ends", cpu_rst_o, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule